// File: doc/BRIEF.md
# Mailbox Memory Write Port

This block sits between a narrow 16-bit register port and a 32-bit memory write port. A host cannot write a full memory word in one register access. Instead it loads a word-aligned target address and a data word, each as two 16-bit halves. It then writes a command to the control register.

On a write command, the block presents the word on the memory port and holds it there until the memory accepts it. It then advances its internal address by one word, so a stream of words can be loaded by rewriting only the data halves and the command. Every accepted word is folded into a running CRC-16. The host can read that CRC back and compare it with its own value to confirm that the whole transfer arrived intact. A command bit clears the CRC before a new transfer.

The register offsets are relative to a parameterised base, 0x0200 by default. Control is at base+0, CRC at base+1, address high/low at base+2/base+3, and data high/low at base+4/base+5.

Top module: `mbox_wr_port`

## Requirements
- R1: After a synchronous active-low reset, the address, data and CRC registers read 0x0000, the control register reads 0x0000 (busy clear), and `mem_we` is low.
- R2: Base+2 holds address bits 31:16 and base+3 holds bits 15:0. Bits 1:0 always read back as zero and are driven as zero on `mem_addr`.
- R3: Base+4 holds data bits 31:16 and base+5 holds bits 15:0. Both halves read back as written, and `mem_wdata` carries {high, low}.
- R4: A control write with bit 15 (execute) and bit 14 (write) both set raises `mem_we` in the next cycle, with the stored address and data. `mem_we`, `mem_addr` and `mem_wdata` stay unchanged until a cycle in which `mem_ready` is high; that cycle completes the write.
- R5: Control bit 8 reads 1 from the cycle after an accepted write command up to and including the cycle in which the memory accepts the word. It reads 0 afterwards.
- R6: A write command that arrives while busy is ignored. Exactly one memory write occurs, and the address and CRC reflect that one word only.
- R7: After each completed write, the internal address becomes the written address plus 4, modulo 2^32.
- R8: Base+1 reads the running CRC-16 with polynomial 0x1021, initial value 0 and no final XOR. It is updated in the cycle after each completed write with the four data bytes, most significant byte first.
- R9: A control write with bit 12 set clears the CRC to 0x0000 in the next cycle. If a write completes in that same cycle, the completing word is folded into the cleared value instead.
- R10: A control write with execute set but the write bit clear causes no memory access and leaves the CRC and the address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 16 | Register offset for reads and writes |
| reg_wdata | input | 16 | Register write data |
| reg_wr | input | 1 | Register write strobe, one per cycle |
| reg_rdata | output | 16 | Register read data for `reg_addr`, combinational |
| mem_addr | output | 32 | Memory word address, low two bits zero |
| mem_wdata | output | 32 | Memory write data |
| mem_we | output | 1 | Memory write request, held until accepted |
| mem_ready | input | 1 | Memory accepts the pending write this cycle |

## Verification
The bench stalls the memory for several cycles, then issues a second write command while the first is still pending. A design that re-arms on that command would write the word twice, or step the address and CRC twice. It clears the CRC in exactly the cycle the memory accepts a word, which catches a design that drops the completing word or ignores the clear. It also writes at the top of the address space to show the address wraps to zero, and sends an execute-without-write command that must touch neither the memory nor the CRC. A long stream under pseudo-random back-pressure compares every accepted address/data pair and the final CRC against a byte-wise model, so a wrong byte order or polynomial shows up as a CRC mismatch.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
// mbox_pkg: shared widths, control bit positions and the CRC step used by
// the mailbox write port. Assumes a register half is exactly half a word.
package mbox_pkg;
    localparam int REG_W     = 16;
    localparam int WORD_W    = 2 * REG_W;
    localparam int CRC_W     = 16;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

    // control register bit positions (host-visible contract)
    localparam int CB_EXEC   = 15;
    localparam int CB_WRITE  = 14;
    localparam int CB_CLRCRC = 12;
    localparam int CB_BUSY   = 8;

    // fold one word into the CRC, most significant bit (and byte) first
    function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] c_in,
                                                   input logic [WORD_W-1:0] w);
        logic [CRC_W-1:0] c;
        c = c_in;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (c[CRC_W-1] ^ w[i])
                c = {c[CRC_W-2:0], 1'b0} ^ CRC_POLY;
            else
                c = {c[CRC_W-2:0], 1'b0};
        end
        return c;
    endfunction
endpackage

// File: rtl/mbox_crc.sv
`timescale 1ns/1ps
// mbox_crc: running CRC over completed words. Assumes clear and fold may
// coincide; the fold then starts from zero.
module mbox_crc
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              fold,
    input  logic [WORD_W-1:0] word,
    output logic [CRC_W-1:0]  crc
);
    logic [CRC_W-1:0] base;

    // starting value for this cycle's update
    always_comb base = clr ? '0 : crc;

    // CRC register: clear and/or fold
    always_ff @(posedge clk) begin
        if (!rst_n)
            crc <= '0;
        else if (fold)
            crc <= crc_fold(base, word);
        else if (clr)
            crc <= '0;
    end

    AST_CRC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !fold |=> crc == '0); // R9
    AST_CRC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !clr && !fold |=> $stable(crc)); // R10
endmodule

// File: rtl/mbox_issue.sv
`timescale 1ns/1ps
// mbox_issue: holds one memory write from command until acceptance.
// Assumes start is only raised while idle; the request is a level that
// stays with fixed address and data until ready.
module mbox_issue
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] addr_in,
    input  logic [WORD_W-1:0] data_in,
    input  logic              mem_ready,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              accept
);
    // completion of the pending write
    always_comb accept = mem_we && mem_ready;

    // request state and captured address/data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (start) begin
            mem_we    <= 1'b1;
            mem_addr  <= {addr_in[WORD_W-1:2], 2'b00};
            mem_wdata <= data_in;
        end else if (accept) begin
            mem_we    <= 1'b0;
        end
    end

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && !mem_ready |=> mem_we && $stable(mem_addr) && $stable(mem_wdata)); // R4
    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr[1:0] == 2'b00); // R2
    AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && !mem_ready |=> $stable(mem_addr)); // R6
endmodule

// File: rtl/mbox_regs.sv
`timescale 1ns/1ps
// mbox_regs: host register decode, address/data storage, command decode
// and read mux. Assumes one register access per cycle; a host write to an
// address half wins over the automatic step in the same cycle.
module mbox_regs
    import mbox_pkg::*;
#(
    parameter logic [REG_W-1:0] BASE = 16'h0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_wr,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              busy,
    input  logic [CRC_W-1:0]  crc,
    input  logic              step,
    input  logic [WORD_W-1:0] step_base,
    output logic [WORD_W-1:0] cur_addr,
    output logic [WORD_W-1:0] cur_data,
    output logic              start,
    output logic              crc_clr
);
    localparam logic [REG_W-1:0] OFS_CTRL = BASE;
    localparam logic [REG_W-1:0] OFS_CRC  = BASE + 16'd1;
    localparam logic [REG_W-1:0] OFS_AHI  = BASE + 16'd2;
    localparam logic [REG_W-1:0] OFS_ALO  = BASE + 16'd3;
    localparam logic [REG_W-1:0] OFS_DHI  = BASE + 16'd4;
    localparam logic [REG_W-1:0] OFS_DLO  = BASE + 16'd5;

    logic ctrl_wr, ahi_wr, alo_wr;

    // write decode
    always_comb begin
        ctrl_wr = reg_wr && (reg_addr == OFS_CTRL);
        ahi_wr  = reg_wr && (reg_addr == OFS_AHI);
        alo_wr  = reg_wr && (reg_addr == OFS_ALO);
        start   = ctrl_wr && reg_wdata[CB_EXEC] && reg_wdata[CB_WRITE] && !busy;
        crc_clr = ctrl_wr && reg_wdata[CB_CLRCRC];
    end

    // address register: step after completion, host halves override
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
        end else begin
            if (step)
                cur_addr <= step_base + 32'd4;
            if (ahi_wr)
                cur_addr[WORD_W-1:REG_W] <= reg_wdata;
            if (alo_wr)
                cur_addr[REG_W-1:0] <= {reg_wdata[REG_W-1:2], 2'b00};
        end
    end

    // data register halves
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_data <= '0;
        end else if (reg_wr && reg_addr == OFS_DHI) begin
            cur_data[WORD_W-1:REG_W] <= reg_wdata;
        end else if (reg_wr && reg_addr == OFS_DLO) begin
            cur_data[REG_W-1:0] <= reg_wdata;
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CTRL: reg_rdata[CB_BUSY] = busy;
            OFS_CRC:  reg_rdata = crc;
            OFS_AHI:  reg_rdata = cur_addr[WORD_W-1:REG_W];
            OFS_ALO:  reg_rdata = cur_addr[REG_W-1:0];
            OFS_DHI:  reg_rdata = cur_data[WORD_W-1:REG_W];
            OFS_DLO:  reg_rdata = cur_data[REG_W-1:0];
            default:  reg_rdata = '0;
        endcase
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step && !ahi_wr && !alo_wr |=> cur_addr == $past(step_base) + 32'd4); // R7
    AST_ADDR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cur_addr[1:0] == 2'b00); // R2
endmodule

// File: rtl/mbox_wr_port.sv
`timescale 1ns/1ps
// mbox_wr_port: mailbox that turns 16-bit register writes into 32-bit
// memory writes with automatic address step and running CRC-16.
// Assumes the memory holds off with mem_ready low as long as it needs.
module mbox_wr_port
    import mbox_pkg::*;
#(
    parameter logic [15:0] REG_BASE = 16'h0200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] reg_addr,
    input  logic [15:0] reg_wdata,
    input  logic        reg_wr,
    output logic [15:0] reg_rdata,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic        mem_we,
    input  logic        mem_ready
);
    logic [WORD_W-1:0] cur_addr, cur_data;
    logic [CRC_W-1:0]  crc;
    logic              start, crc_clr, accept;

    mbox_regs #(.BASE(REG_BASE)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rdata (reg_rdata),
        .busy      (mem_we),
        .crc       (crc),
        .step      (accept),
        .step_base (mem_addr),
        .cur_addr  (cur_addr),
        .cur_data  (cur_data),
        .start     (start),
        .crc_clr   (crc_clr)
    );

    mbox_issue u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .addr_in   (cur_addr),
        .data_in   (cur_data),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .accept    (accept)
    );

    mbox_crc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .fold  (accept),
        .word  (mem_wdata),
        .crc   (crc)
    );
endmodule

// File: tb/mbox_wr_port_test.sv
`timescale 1ns/1ps
module mbox_wr_port_test;
    localparam logic [15:0] CTRL = 16'h0200, CRC = 16'h0201, AHI = 16'h0202,
                            ALO = 16'h0203, DHI = 16'h0204, DLO = 16'h0205;

    logic        clk = 0, rst_n = 0, reg_wr = 0, mem_ready = 0;
    logic [15:0] reg_addr = 0, reg_wdata = 0, reg_rdata;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_we;

    mbox_wr_port uut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
                      .reg_wr(reg_wr), .reg_rdata(reg_rdata), .mem_addr(mem_addr),
                      .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_ready(mem_ready));

    always #2 clk = ~clk;

    int checks = 0, fails = 0, accepts = 0, ready_mode = 0;
    logic [7:0]  lfsr = 8'h5A;
    logic [63:0] exp_q[$];
    logic [31:0] addr_m = 0, data_m = 0;
    logic [15:0] crc_m = 0;

    function automatic logic [15:0] crc_add(input logic [15:0] c, input logic [31:0] w);
        for (int b = 3; b >= 0; b--) begin
            c = c ^ {w[b*8 +: 8], 8'h00};
            for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return c;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory ready driver, applied after the input-drive point of each cycle
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready = (ready_mode == 1) || (ready_mode == 2 && lfsr[0]);
    end

    // monitor: compare each accepted memory write with the scoreboard
    always @(negedge clk) begin
        if (rst_n && mem_we && mem_ready) begin
            accepts++;
            if (exp_q.size() == 0) begin
                chk("R4 unexpected write", {mem_addr, mem_wdata}, 64'hx);
            end else begin
                chk("R4 write addr/data", {mem_addr, mem_wdata}, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(posedge clk); #0.5;
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(posedge clk); #0.5;
        reg_wr = 0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #0.2 v = reg_rdata;
    endtask

    task automatic set_addr(input logic [15:0] hi, input logic [15:0] lo);
        wr(AHI, hi); wr(ALO, lo);
        addr_m = {hi, lo[15:2], 2'b00};
    endtask

    task automatic set_data(input logic [15:0] hi, input logic [15:0] lo);
        wr(DHI, hi); wr(DLO, lo);
        data_m = {hi, lo};
    endtask

    // driver: push expected write, update model, issue command
    task automatic exec(input logic [15:0] cmd);
        exp_q.push_back({addr_m, data_m});
        crc_m  = crc_add(crc_m, data_m);
        addr_m = addr_m + 32'd4;
        wr(CTRL, cmd);
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int i = 0; i < 400; i++) begin
            rd(CTRL, v);
            if (v[8] == 1'b0) break;
        end
    endtask

    task automatic chk_state(input string req);
        logic [15:0] h, l, c;
        rd(AHI, h); rd(ALO, l); rd(CRC, c);
        chk({req, " addr"}, {h, l}, addr_m);
        chk({req, " crc"}, c, crc_m);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #400000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [15:0] v;
        int a0;
        repeat (5) @(posedge clk);
        #0.5 rst_n = 1;

        // R1 reset state
        rd(CTRL, v); chk("R1 ctrl", v, 0);
        rd(CRC, v);  chk("R1 crc", v, 0);
        rd(ALO, v);  chk("R1 addr", v, 0);
        rd(DHI, v);  chk("R1 data", v, 0);
        chk("R1 mem_we", mem_we, 0);

        // R2 address halves, low bits forced zero
        set_addr(16'h0001, 16'h2347);
        rd(ALO, v); chk("R2 addr low", v, 16'h2344);
        rd(AHI, v); chk("R2 addr high", v, 16'h0001);

        // R3 data halves
        set_data(16'hDEAD, 16'hBEEF);
        rd(DHI, v); chk("R3 data high", v, 16'hDEAD);
        rd(DLO, v); chk("R3 data low", v, 16'hBEEF);

        // R8/R7 single write, memory always ready
        ready_mode = 1;
        exec(16'hC000); wait_idle();
        chk_state("R8 R7 single");

        // R4/R5 stalled write, then R6 command while busy
        ready_mode = 0;
        set_data(16'h0123, 16'h4567);
        exec(16'hC000);
        rd(CTRL, v); chk("R5 busy set", v, 16'h0100);
        chk("R4 request held", {mem_we, mem_addr, mem_wdata}, {1'b1, addr_m - 32'd4, data_m});
        repeat (3) @(posedge clk);
        rd(CTRL, v); chk("R5 busy during stall", v, 16'h0100);
        chk("R4 stable during stall", {mem_addr, mem_wdata}, {addr_m - 32'd4, data_m});
        a0 = accepts;
        wr(CTRL, 16'hC000);
        ready_mode = 1;
        wait_idle();
        repeat (4) @(posedge clk);
        rd(CTRL, v); chk("R5 busy clear", v, 0);
        chk("R6 single write", accepts - a0, 1);
        chk_state("R6 state");

        // R10 execute without write bit
        a0 = accepts;
        wr(CTRL, 16'h8000);
        repeat (4) @(posedge clk);
        chk("R10 no access", accepts - a0, 0);
        rd(CTRL, v); chk("R10 not busy", v, 0);
        chk_state("R10 state");

        // R9 plain clear
        wr(CTRL, 16'h1000); crc_m = 0;
        rd(CRC, v); chk("R9 cleared", v, 0);

        // R8 stream under pseudo-random back-pressure
        ready_mode = 2;
        for (int i = 0; i < 24; i++) begin
            set_data(16'h1000 + 16'(i * 7), 16'hA5A5 ^ 16'(i * 913));
            exec(16'hC000);
            wait_idle();
        end
        ready_mode = 1;
        repeat (3) @(posedge clk);
        chk_state("R8 stream");

        // R9 clear in the same cycle the memory accepts
        ready_mode = 0;
        set_data(16'hCAFE, 16'h0042);
        exec(16'hC000);
        repeat (3) @(posedge clk);
        @(posedge clk); #0.5;
        reg_addr = CTRL; reg_wdata = 16'h1000; reg_wr = 1; ready_mode = 1;
        @(posedge clk); #0.5;
        reg_wr = 0;
        crc_m = crc_add(16'h0000, data_m);
        wait_idle();
        chk_state("R9 clear with completion");

        // R9 clear and write command together
        set_data(16'h55AA, 16'h33CC);
        crc_m = 0;
        exec(16'hD000); wait_idle();
        chk_state("R9 clear plus execute");

        // R7 wrap at top of address space
        set_addr(16'hFFFF, 16'hFFFC);
        exec(16'hC000); wait_idle();
        rd(AHI, v); chk("R7 wrap high", v, 0);
        rd(ALO, v); chk("R7 wrap low", v, 0);

        repeat (4) @(posedge clk);
        chk("R4 scoreboard drained", exp_q.size(), 0);
        summary();
    end
endmodule